// File: doc/BRIEF.md
# Write Completion Status Generator

This block supplies the status a host reads back from a non-volatile memory while an internal program or erase is running. A single word is not enough to show progress, so two status bits carry it. The polling bit (bit 7) shows the complement of the word being programmed, or a zero during an erase. It changes to the final value once the operation ends. The toggle bit (bit 6) changes value on every qualified read access for as long as the operation runs, and then holds still. The block also drives a ready/busy line. It is modelled as an output enable plus a fixed low level, so the line floats whenever it is not pulling down.

The status is armed only after enough write strobes of the command sequence have been seen: four for a program and six for an erase. After the operation ends, a configurable recovery count must expire before the block reports that array data may be trusted again. The operation kind and the data bit are captured on the cycle the busy flag rises.

Top module: `wstat_gen`

## Requirements
- R1: After reset, dq7 is 1, dq6 is 1, stat_act is 0, ry_oe is 0, ry_lvl is 0 and data_ok is 1.
- R2: For a program (op_kind 0), dq7 is the inverse of the captured data bit one cycle after busy rises, and equals that bit one cycle after busy falls.
- R3: For an erase (op_kind 1), dq7 is 0 one cycle after busy rises, and 1 one cycle after busy falls.
- R4: dq6 is set to 1 when an operation starts. Each clock cycle with rd_stb high, ce_n low and stat_act high inverts dq6 at the next edge. A read with ce_n high, a read while stat_act is low, and any read after the operation has ended leave dq6 unchanged.
- R5: stat_act is high one cycle after busy rises only if at least 4 (program) or 6 (erase) wr_stb pulses arrived while idle since the last operation end or reset. Pulses that arrive during busy are not counted.
- R6: ry_oe is high exactly while the registered busy is 1, ce_n is 0 and rst_n is 1. It drops in the same cycle that ce_n rises or rst_n falls. ry_lvl is always 0.
- R7: data_ok is low while busy is registered, stays low for REC_CYC-1 further cycles after the first idle cycle, and then goes high.
- R8: op_kind and wr_bit7 are captured on the cycle busy rises. Later changes to them during the operation do not alter dq7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also floats ready/busy |
| ce_n | input | 1 | Chip enable, active low |
| rd_stb | input | 1 | One-cycle read access strobe |
| wr_stb | input | 1 | One-cycle write strobe of a command sequence |
| busy | input | 1 | Internal operation in progress |
| op_kind | input | 1 | 0 program, 1 erase; captured when busy rises |
| wr_bit7 | input | 1 | Bit 7 of the word being programmed |
| dq7 | output | 1 | Polling status bit |
| dq6 | output | 1 | Toggle status bit |
| stat_act | output | 1 | Status bits are armed and valid |
| ry_oe | output | 1 | Ready/busy pull-down enable |
| ry_lvl | output | 1 | Level driven when ry_oe is high (always 0) |
| data_ok | output | 1 | Recovery interval elapsed; array reads valid |

## Verification
The stimulus uses seeded random operations. Each one picks program or erase at random, along with a random data bit and a write strobe count that either reaches the arming threshold or stops short of it. A random number of reads is then issued, some with the chip deselected. Full-threshold runs show that the toggle bit inverts per access and not per clock. Short runs show that arming depends on the operation kind, and deselected reads show both that ready/busy floats and that the toggle holds. Directed cases cover reset values, strobes issued during busy, input changes during an operation, and a reset in the middle of an operation. Every completion is checked against the exact cycle at which recovery finishes.

// File: rtl/wstat_pkg.sv
package wstat_pkg;
    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_e;

    // Write strobes of the command sequence required before status is valid
    function automatic int strobes_needed(op_kind_e kind, int prog_n, int erase_n);
        return (kind == OP_ERASE) ? erase_n : prog_n;
    endfunction
endpackage

// File: rtl/wstat_arm.sv
module wstat_arm
    import wstat_pkg::*;
#(
    parameter int PROG_STROBES  = 4,
    parameter int ERASE_STROBES = 6
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_stb,
    input  logic     busy_q,
    input  logic     busy_fall,
    input  op_kind_e kind_q,
    output logic     armed
);
    localparam int MAXN  = (ERASE_STROBES > PROG_STROBES) ? ERASE_STROBES : PROG_STROBES;
    localparam int CNT_W = $clog2(MAXN + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } arm_st_t;

    arm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (busy_fall) begin
            st_d.cnt = '0;
        end else if (wr_stb && !busy_q && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = busy_q && (int'(st_q.cnt) >= strobes_needed(kind_q, PROG_STROBES, ERASE_STROBES));
endmodule

// File: rtl/wstat_tgl.sv
module wstat_tgl #(
    parameter logic TGL_INIT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic op_start,
    input  logic rd_hit,
    output logic tgl
);
    typedef struct packed {
        logic tgl;
    } tgl_st_t;

    tgl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (op_start) begin
            st_d.tgl = TGL_INIT;
        end else if (rd_hit) begin
            st_d.tgl = ~st_q.tgl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tgl <= TGL_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign tgl = st_q.tgl;
endmodule

// File: rtl/wstat_recov.sv
module wstat_recov #(
    parameter int REC_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_q,
    input  logic busy_fall,
    output logic data_ok
);
    localparam int REC_W = $clog2(REC_CYC + 2);
    localparam logic [REC_W-1:0] REC_LOAD = REC_W'(REC_CYC);

    typedef struct packed {
        logic [REC_W-1:0] cnt;
    } rec_st_t;

    rec_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (busy_fall) begin
            st_d.cnt = REC_LOAD;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_ok = !busy_q && (st_q.cnt == '0);
endmodule

// File: rtl/wstat_gen.sv
module wstat_gen
    import wstat_pkg::*;
#(
    parameter int   PROG_STROBES  = 4,
    parameter int   ERASE_STROBES = 6,
    parameter int   REC_CYC       = 8,
    parameter logic TGL_INIT      = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic rd_stb,
    input  logic wr_stb,
    input  logic busy,
    input  logic op_kind,
    input  logic wr_bit7,
    output logic dq7,
    output logic dq6,
    output logic stat_act,
    output logic ry_oe,
    output logic ry_lvl,
    output logic data_ok
);
    typedef struct packed {
        logic     busy;
        op_kind_e kind;
        logic     bit7;
    } top_st_t;

    top_st_t st_d, st_q;
    logic    op_start;
    logic    busy_fall;
    logic    armed;
    logic    rd_hit;

    assign op_start  = busy && !st_q.busy;
    assign busy_fall = st_q.busy && !busy;

    always_comb begin
        st_d      = st_q;
        st_d.busy = busy;
        if (op_start) begin
            st_d.kind = op_kind_e'(op_kind);
            st_d.bit7 = wr_bit7;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy <= 1'b0;
            st_q.kind <= OP_PROG;
            st_q.bit7 <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    wstat_arm #(
        .PROG_STROBES (PROG_STROBES),
        .ERASE_STROBES(ERASE_STROBES)
    ) u_arm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .busy_q   (st_q.busy),
        .busy_fall(busy_fall),
        .kind_q   (st_q.kind),
        .armed    (armed)
    );

    assign rd_hit = rd_stb && !ce_n && armed;

    wstat_tgl #(
        .TGL_INIT(TGL_INIT)
    ) u_tgl (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_start(op_start),
        .rd_hit  (rd_hit),
        .tgl     (dq6)
    );

    wstat_recov #(
        .REC_CYC(REC_CYC)
    ) u_rec (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_q   (st_q.busy),
        .busy_fall(busy_fall),
        .data_ok  (data_ok)
    );

    always_comb begin
        if (st_q.busy) begin
            dq7 = (st_q.kind == OP_ERASE) ? 1'b0 : ~st_q.bit7;
        end else begin
            dq7 = (st_q.kind == OP_ERASE) ? 1'b1 : st_q.bit7;
        end
    end

    assign stat_act = armed;
    assign ry_oe    = st_q.busy && !ce_n && rst_n;
    assign ry_lvl   = 1'b0;
endmodule

// File: rtl/wstat_chk.sv
module wstat_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_n,
    input logic rd_stb,
    input logic busy,
    input logic dq6,
    input logic stat_act,
    input logic ry_oe,
    input logic data_ok
);
    // R6: pull-down only while selected and out of reset
    p_ry_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ry_oe |-> !ce_n);

    // R4: a qualified read inverts the toggle bit
    p_tgl_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_act && rd_stb && !ce_n) |=> (dq6 != $past(dq6)));

    // R4: with no read and no operation start the toggle holds
    p_tgl_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !rd_stb) |=> $stable(dq6));

    // R7: array data never reported valid right after a busy cycle
    p_rec_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !data_ok);

    // R5: status can only be armed when busy was registered
    p_arm_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_act |-> $past(busy));
endmodule

bind wstat_gen wstat_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .rd_stb  (rd_stb),
    .busy    (busy),
    .dq6     (dq6),
    .stat_act(stat_act),
    .ry_oe   (ry_oe),
    .data_ok (data_ok)
);

// File: tb/sim_wstat_gen.sv
module sim_wstat_gen;
    localparam int CLK_PERIOD = 10;
    localparam int REC_CYC    = 8;

    logic clk = 1'b0;
    logic rst_n, ce_n, rd_stb, wr_stb, busy, op_kind, wr_bit7;
    logic dq7, dq6, stat_act, ry_oe, ry_lvl, data_ok;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wstat_gen #(.REC_CYC(REC_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .busy(busy), .op_kind(op_kind), .wr_bit7(wr_bit7),
        .dq7(dq7), .dq6(dq6), .stat_act(stat_act), .ry_oe(ry_oe),
        .ry_lvl(ry_lvl), .data_ok(data_ok)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_dq7(input logic kind, input logic bitv, input logic running);
        if (kind) return running ? 1'b0 : 1'b1;
        return running ? ~bitv : bitv;
    endfunction

    function automatic int need_of(input logic kind);
        return kind ? 6 : 4;
    endfunction

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) wr_stb = 1'b1;
            @(negedge clk) wr_stb = 1'b0;
        end
    endtask

    task automatic check_reset_vals();
        #1;
        check("R1 dq7", dq7, 1'b1);
        check("R1 dq6", dq6, 1'b1);
        check("R1 stat_act", stat_act, 1'b0);
        check("R1 ry_oe", ry_oe, 1'b0);
        check("R1 ry_lvl", ry_lvl, 1'b0);
        check("R1 data_ok", data_ok, 1'b1);
    endtask

    // one operation: returns nothing, checks R2..R8 along the way
    task automatic run_op(input logic kind, input logic bitv, input int nstb, input int nrd);
        logic armed_e;
        logic tgl_e;
        armed_e = (nstb >= need_of(kind));
        strobes(nstb);
        @(negedge clk);
        busy = 1'b1; op_kind = kind; wr_bit7 = bitv;
        @(negedge clk);
        #1;
        check(kind ? "R3 dq7 busy" : "R2 dq7 busy", dq7, exp_dq7(kind, bitv, 1'b1));
        check("R5 stat_act", stat_act, armed_e);
        check("R6 ry_oe busy", ry_oe, 1'b1);
        check("R7 data_ok busy", data_ok, 1'b0);
        tgl_e = 1'b1;
        // R8: scramble the captured inputs
        op_kind = ~kind; wr_bit7 = ~bitv;
        for (int r = 0; r < nrd; r++) begin
            logic desel;
            desel = ($urandom % 4) == 0;
            @(negedge clk);
            ce_n = desel; rd_stb = 1'b1;
            #1;
            check("R4 dq6 read", dq6, tgl_e);
            check("R6 ry_oe select", ry_oe, !desel);
            check("R8 dq7 held", dq7, exp_dq7(kind, bitv, 1'b1));
            @(negedge clk);
            rd_stb = 1'b0; ce_n = 1'b0;
            if (!desel && armed_e) tgl_e = ~tgl_e;
        end
        #1;
        check("R4 dq6 after reads", dq6, tgl_e);
        busy = 1'b0;
        @(negedge clk);
        #1;
        check(kind ? "R3 dq7 done" : "R2 dq7 done", dq7, exp_dq7(kind, bitv, 1'b0));
        check("R6 ry_oe idle", ry_oe, 1'b0);
        check("R7 data_ok start", data_ok, 1'b0);
        for (int j = 1; j < REC_CYC; j++) begin
            @(negedge clk);
            #1;
            check("R7 data_ok wait", data_ok, 1'b0);
        end
        @(negedge clk);
        #1;
        check("R7 data_ok end", data_ok, 1'b1);
        // reads after completion do not toggle
        @(negedge clk) rd_stb = 1'b1;
        @(negedge clk) rd_stb = 1'b0;
        #1;
        check("R4 dq6 stopped", dq6, tgl_e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20241));
        rst_n = 1'b0; ce_n = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0;
        busy = 1'b0; op_kind = 1'b0; wr_bit7 = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_vals();
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_vals();

        // directed: program and erase, full sequences
        run_op(1'b0, 1'b1, 4, 3);
        run_op(1'b0, 1'b0, 4, 4);
        run_op(1'b1, 1'b0, 6, 5);
        // directed: erase with only program-length sequence stays unarmed
        run_op(1'b1, 1'b1, 4, 3);

        // R5: strobes during busy are not counted
        strobes(2);
        @(negedge clk) busy = 1'b1; op_kind = 1'b0;
        strobes(5);
        #1;
        check("R5 strobes while busy ignored", stat_act, 1'b0);
        @(negedge clk) rd_stb = 1'b1;
        #1;
        check("R4 unarmed read dq6", dq6, 1'b1);
        @(negedge clk) rd_stb = 1'b0;
        #1;
        check("R4 unarmed no flip", dq6, 1'b1);
        @(negedge clk) busy = 1'b0;
        repeat (REC_CYC + 2) @(negedge clk);

        // R6: reset during an armed operation floats ready/busy at once
        strobes(4);
        @(negedge clk) busy = 1'b1; op_kind = 1'b0; wr_bit7 = 1'b0;
        @(negedge clk);
        #1;
        check("R6 ry_oe before reset", ry_oe, 1'b1);
        rst_n = 1'b0;
        #1;
        check("R6 ry_oe in reset", ry_oe, 1'b0);
        busy = 1'b0;
        @(negedge clk);
        check_reset_vals();
        rst_n = 1'b1;

        // random operations
        for (int it = 0; it < 40; it++) begin
            logic kind, bitv;
            int n;
            kind = 1'($urandom % 2);
            bitv = 1'($urandom % 2);
            if (($urandom % 4) == 0) n = int'($urandom % need_of(kind));
            else n = need_of(kind) + int'($urandom % 2);
            run_op(kind, bitv, n, 1 + int'($urandom % 6));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule